// File: doc/BRIEF.md
# Serial Register Writer with Deferred Non-Volatile Commit

This block is the slave side of a 4-wire serial link that loads a small register file. Each frame carries an address, a command code and a 10-bit value. The register file has two kinds of slot. Volatile slots change as soon as a frame is complete. Non-volatile slots are modelled as a register array, and a write to one of them is held until the chip select is released. The write is then committed after a fixed busy time.

The serial pins are brought into the system clock domain through synchronisers and sampled there. The link runs in mode 0: data is captured on the rising serial-clock edge and the reply line changes on the falling edge. The reply line tells the host whether the header of the current frame was accepted. While a commit is in progress, a busy flag is raised and frames aimed at non-volatile slots are refused. The chip select may be asserted again at once to reach the volatile slots during that time.

Top module: `spi_regw_top`

## Requirements
- R1: A frame is shifted in most significant bit first: bits 15..12 are the address, bits 11..10 the command code (00 = write, any other code is invalid), and bits 9..0 the data value.
- R2: Addresses 0, 1, 4 and 5 are volatile slots 0..3, in that address order. A valid write to one of them updates the slot once the 16th bit has been captured, while the chip select is still low.
- R3: A frame of fewer than 16 clocks writes nothing. A non-volatile frame with any count other than exactly 16 clocks starts no commit.
- R4: Addresses 2, 3 and 6..15 are non-volatile slots 0..11, in ascending address order. A valid write to one of them starts a commit only when the chip select rises after exactly 16 clocks. The slot takes the new value when the commit ends, and not before.
- R5: `nv_busy` is 1 for COMMIT_CYCLES system clocks from the start of a commit, and 0 at all other times.
- R6: While `nv_busy` is 1, a frame aimed at a non-volatile address is refused and changes no slot. Frames aimed at volatile addresses are still accepted.
- R7: After the falling edge that follows the 6th captured bit, `spi_sdo` is 1 if the header is valid (command 00 and an accepted address) and 0 if it is not. `spi_sdo` idles at 1.
- R8: Once an error occurs, `spi_sdo` stays 0 until the chip select rises. An error is either an invalid header or a 17th clock after a complete non-volatile frame. The error also discards the pending commit.
- R9: The chip select may be asserted again right after release while a commit is still running, and a volatile write made in that window takes effect.
- R10: After reset, all volatile and non-volatile slots read 0, `nv_busy` is 0 and `spi_sdo` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Header validity / error reply |
| nv_busy | output | 1 | Commit in progress |
| vol_regs_o | output | 40 | Volatile slots, slot k at bits 10k+9..10k |
| nv_regs_o | output | 120 | Non-volatile slots, slot k at bits 10k+9..10k |

## Verification
The bench builds the block with COMMIT_CYCLES = 400 and two synchroniser stages. At the bench's serial clock rate a whole frame takes well under one commit. A volatile frame followed by a refused non-volatile frame therefore both fall inside one busy window, and the busy length can be measured against the parameter. The 400-clock window keeps every committed write short enough that a run of several dozen random frames, with lengths of 3, 8, 15, 16 and 17 clocks, fits the cycle budget.

// File: rtl/spi_regw_pkg.sv
package spi_regw_pkg;

  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 4;
  localparam int CMD_W      = 2;
  localparam int DATA_W     = 10;
  localparam int HDR_BITS   = ADDR_W + CMD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
  localparam int VOL_N      = 4;
  localparam int NV_N       = 12;
  localparam int VOL_IDX_W  = $clog2(VOL_N);
  localparam int NV_IDX_W   = $clog2(NV_N);

  localparam logic [CMD_W-1:0] CMD_WRITE = 2'b00;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    addr_t addr;
    data_t data;
  } wr_req_t;

  function automatic logic is_volatile(input addr_t a);
    return (a == 4'h0) || (a == 4'h1) || (a == 4'h4) || (a == 4'h5);
  endfunction

  function automatic logic [VOL_IDX_W-1:0] vol_index(input addr_t a);
    return {a[2], a[0]};
  endfunction

  function automatic logic [NV_IDX_W-1:0] nv_index(input addr_t a);
    return (a < 4'h4) ? NV_IDX_W'(a - 4'h2) : NV_IDX_W'(a - 4'h4);
  endfunction

endpackage

// File: rtl/spi_regw_sync.sv
module spi_regw_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_regw_frame.sv
module spi_regw_frame
  import spi_regw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sck_rise,
  input  logic    sck_fall,
  input  logic    cs_act,
  input  logic    cs_rise,
  input  logic    sdi,
  input  logic    busy_i,
  output logic    vol_we_o,
  output wr_req_t vol_req_o,
  output logic    nv_start_o,
  output wr_req_t nv_req_o,
  output logic    sdo_o
);

  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic [FRAME_BITS-1:0] sh_q, sh_d, sh_in;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  err_q, err_d;
  logic                  pend_q, pend_d;
  logic                  sdo_q, sdo_d;
  wr_req_t               req_q, req_d;
  addr_t                 hdr_addr;
  logic [CMD_W-1:0]      hdr_cmd;
  logic                  hdr_ok;

  always_comb begin
    sh_in     = {sh_q[FRAME_BITS-2:0], sdi};
    hdr_addr  = sh_in[HDR_BITS-1 -: ADDR_W];
    hdr_cmd   = sh_in[CMD_W-1:0];
    hdr_ok    = (hdr_cmd == CMD_WRITE) && (is_volatile(hdr_addr) || !busy_i);
    vol_req_o = '{addr: sh_in[FRAME_BITS-1 -: ADDR_W], data: sh_in[DATA_W-1:0]};

    sh_d       = sh_q;
    cnt_d      = cnt_q;
    err_d      = err_q;
    pend_d     = pend_q;
    req_d      = req_q;
    sdo_d      = sdo_q;
    vol_we_o   = 1'b0;
    nv_start_o = 1'b0;

    if (cs_rise) begin
      nv_start_o = pend_q && !err_q && (cnt_q == CNT_FULL);
      cnt_d      = '0;
      err_d      = 1'b0;
      pend_d     = 1'b0;
      sdo_d      = 1'b1;
    end else if (cs_act && sck_rise) begin
      sh_d  = sh_in;
      cnt_d = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
      if ((cnt_q == CNT_HDR) && !hdr_ok) err_d = 1'b1;
      if ((cnt_q == CNT_LAST) && !err_q) begin
        if (is_volatile(vol_req_o.addr)) begin
          vol_we_o = 1'b1;
        end else begin
          pend_d = 1'b1;
          req_d  = vol_req_o;
        end
      end
      if ((cnt_q >= CNT_FULL) && pend_q) begin
        err_d  = 1'b1;
        pend_d = 1'b0;
      end
    end else if (cs_act && sck_fall) begin
      sdo_d = ~err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= '0;
      sdo_q  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      sdo_q  <= sdo_d;
    end
  end

  assign nv_req_o = req_q;
  assign sdo_o    = sdo_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !cs_rise |=> err_q) else $error("error flag cleared early"); // R8

  AST_NO_PEND_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !pend_q) else $error("pending commit survived an error"); // R8

endmodule

// File: rtl/spi_regw_commit.sv
module spi_regw_commit
  import spi_regw_pkg::*;
#(
  parameter int COMMIT_CYCLES = 5000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  wr_req_t req_i,
  output logic    busy_o,
  output logic    we_o,
  output wr_req_t we_req_o
);

  localparam int TW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(COMMIT_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [TW-1:0] tmr_q, tmr_d;
  wr_req_t       req_q, req_d;

  always_comb begin
    busy_d = busy_q;
    tmr_d  = tmr_q;
    req_d  = req_q;
    we_o   = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      tmr_d  = T_LOAD;
      req_d  = req_i;
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_d = 1'b0;
        we_o   = 1'b1;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      req_q  <= '0;
    end else begin
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
      req_q  <= req_d;
    end
  end

  assign busy_o   = busy_q;
  assign we_req_o = req_q;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q) else $error("commit started while busy"); // R6

endmodule

// File: rtl/spi_regw_top.sv
module spi_regw_top
  import spi_regw_pkg::*;
#(
  parameter int COMMIT_CYCLES = 5000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sck,
  input  logic                    spi_cs_n,
  input  logic                    spi_sdi,
  output logic                    spi_sdo,
  output logic                    nv_busy,
  output logic [VOL_N*DATA_W-1:0] vol_regs_o,
  output logic [NV_N*DATA_W-1:0]  nv_regs_o
);

  logic [2:0] pins_s;
  logic       csn_s, sck_s, sdi_s;
  logic       csn_d_q, sck_d_q;
  logic       sck_rise, sck_fall, cs_rise;
  logic       vol_we, nv_start, nv_we;
  wr_req_t    vol_req, nv_req, nv_we_req;

  spi_regw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_cs_n, spi_sck, spi_sdi}),
    .q_o   (pins_s)
  );

  assign {csn_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d_q <= 1'b1;
      sck_d_q <= 1'b0;
    end else begin
      csn_d_q <= csn_s;
      sck_d_q <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d_q;
  assign sck_fall = ~sck_s & sck_d_q;
  assign cs_rise  = csn_s & ~csn_d_q;

  spi_regw_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .cs_act     (~csn_s),
    .cs_rise    (cs_rise),
    .sdi        (sdi_s),
    .busy_i     (nv_busy),
    .vol_we_o   (vol_we),
    .vol_req_o  (vol_req),
    .nv_start_o (nv_start),
    .nv_req_o   (nv_req),
    .sdo_o      (spi_sdo)
  );

  spi_regw_commit #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (nv_start),
    .req_i    (nv_req),
    .busy_o   (nv_busy),
    .we_o     (nv_we),
    .we_req_o (nv_we_req)
  );

  for (genvar v = 0; v < VOL_N; v++) begin : g_vol
    data_t q;
    logic  en;
    assign en = vol_we && (vol_index(vol_req.addr) == VOL_IDX_W'(v));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= vol_req.data;
    end
    assign vol_regs_o[v*DATA_W +: DATA_W] = q;
  end

  for (genvar n = 0; n < NV_N; n++) begin : g_nv
    data_t q;
    logic  en;
    assign en = nv_we && (nv_index(nv_we_req.addr) == NV_IDX_W'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nv_we_req.data;
    end
    assign nv_regs_o[n*DATA_W +: DATA_W] = q;
  end

  AST_COMMIT_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> cs_rise) else $error("commit without chip-select release"); // R4

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |=> nv_busy) else $error("busy not raised by commit"); // R5

  AST_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> nv_busy) else $error("store written outside commit"); // R5

  AST_VOL_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    vol_we |-> is_volatile(vol_req.addr)) else $error("volatile write to other address"); // R2

endmodule

// File: tb/spi_regw_top_tb.sv
module spi_regw_top_tb;

  localparam int COMMIT = 400;
  localparam int HP     = 5;

  logic         clk = 1'b0;
  logic         rst_n, sck, cs_n, sdi;
  wire          sdo, busy;
  wire [39:0]   vol_o;
  wire [119:0]  nv_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [9:0] m_vol [4];
  logic [9:0] m_nv  [12];

  always #4 clk = ~clk;

  spi_regw_top #(.COMMIT_CYCLES(COMMIT), .SYNC_STAGES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (sck),
    .spi_cs_n   (cs_n),
    .spi_sdi    (sdi),
    .spi_sdo    (sdo),
    .nv_busy    (busy),
    .vol_regs_o (vol_o),
    .nv_regs_o  (nv_o)
  );

  function automatic bit tb_is_vol(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h4, 4'h5: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  function automatic int tb_vol_idx(input logic [3:0] a);
    case (a)
      4'h0: return 0;
      4'h1: return 1;
      4'h4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int tb_nv_idx(input logic [3:0] a);
    if (a == 4'h2) return 0;
    if (a == 4'h3) return 1;
    return int'(a) - 4;
  endfunction

  function automatic bit exp_valid(input logic [3:0] a, input logic [1:0] c, input bit bsy);
    return (c == 2'b00) && (tb_is_vol(a) || !bsy);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++)  chk(req, $sformatf("vol slot %0d", i), vol_o[i*10 +: 10], m_vol[i]);
    for (int i = 0; i < 12; i++) chk(req, $sformatf("nv slot %0d", i), nv_o[i*10 +: 10], m_nv[i]);
  endtask

  task automatic send(input logic [15:0] w, input int nbits,
                      output logic s7, output logic s_end, output logic [39:0] vb);
    s7   = 1'b1;
    cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'($urandom);
      tick(HP);
      if (i == 6) s7 = sdo;
      sck = 1'b1;
      tick(HP);
      sck = 1'b0;
    end
    tick(HP + 2);
    s_end = sdo;
    vb    = vol_o;
    cs_n  = 1'b1;
    tick(HP);
  endtask

  // Sends one frame, checks the reply line, updates the volatile model; returns commit flag
  task automatic run_frame(input logic [3:0] a, input logic [1:0] c, input logic [9:0] d,
                           input int nbits, input bit bsy, output bit commit);
    logic s7, s_end;
    logic [39:0] vb;
    bit ok, exp_end;
    ok = exp_valid(a, c, bsy);
    send({a, c, d}, nbits, s7, s_end, vb);
    commit = 1'b0;
    if (nbits >= 7) chk("R7", "sdo after header", s7, ok);
    exp_end = 1'b1;
    if (nbits >= 7 && !ok) exp_end = 1'b0;
    if (ok && !tb_is_vol(a) && nbits >= 17) exp_end = 1'b0;
    chk("R8", "sdo at frame end", s_end, exp_end);
    if (nbits >= 16 && ok) begin
      if (tb_is_vol(a)) begin
        m_vol[tb_vol_idx(a)] = d;
        chk("R2", "volatile value before CS release", vb[tb_vol_idx(a)*10 +: 10], d);
      end else if (nbits == 16) begin
        commit = 1'b1;
      end
    end
    chk("R10", "sdo idle after release", sdo, 1);
  endtask

  initial begin
    bit cm;
    int cyc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    for (int i = 0; i < 4; i++)  m_vol[i] = '0;
    for (int i = 0; i < 12; i++) m_nv[i]  = '0;
    tick(5);
    chk("R10", "busy in reset", busy, 0);
    chk("R10", "sdo in reset", sdo, 1);
    rst_n = 1'b1;
    tick(5);
    check_regs("R10");

    // R1/R2: volatile write to address 4 lands in slot 2
    run_frame(4'h4, 2'b00, 10'h2A5, 16, 0, cm);
    check_regs("R1");

    // R4/R5: non-volatile write to address 6 (slot 2), busy measured
    run_frame(4'h6, 2'b00, 10'h17C, 16, 0, cm);
    chk("R5", "busy right after release", busy, 1);
    chk("R4", "store unchanged while busy", nv_o[2*10 +: 10], 0);
    cyc = 0;
    while (busy && cyc < COMMIT + 50) begin tick(1); cyc++; end
    chk("R5", "busy length in window", (cyc >= COMMIT - 10 && cyc <= COMMIT) ? 1 : 0, 1);
    m_nv[2] = 10'h17C;
    tick(2);
    check_regs("R4");

    // R9/R6: during a commit, a volatile write works and a non-volatile one is refused
    run_frame(4'h3, 2'b00, 10'h0F0, 16, 0, cm);
    chk("R5", "busy after second commit", busy, 1);
    run_frame(4'h1, 2'b00, 10'h3C3, 16, 1, cm);
    chk("R9", "volatile slot 1 during commit", vol_o[1*10 +: 10], 10'h3C3);
    run_frame(4'h9, 2'b00, 10'h155, 16, 1, cm);
    chk("R6", "refused frame starts no commit", cm, 0);
    chk("R6", "still busy", busy, 1);
    tick(COMMIT + 10);
    m_nv[1] = 10'h0F0;
    chk("R5", "busy clear after commit", busy, 0);
    check_regs("R6");

    // R3: short and long non-volatile frames
    run_frame(4'hA, 2'b00, 10'h1FF, 15, 0, cm);
    tick(4);
    chk("R3", "15-clock frame no busy", busy, 0);
    run_frame(4'hA, 2'b00, 10'h1FF, 17, 0, cm);
    tick(4);
    chk("R8", "17-clock frame no busy", busy, 0);
    run_frame(4'h0, 2'b00, 10'h111, 15, 0, cm);
    check_regs("R3");

    // R7: invalid command code
    run_frame(4'h0, 2'b10, 10'h222, 16, 0, cm);
    check_regs("R7");

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic [3:0] a;
      logic [1:0] c;
      logic [9:0] d;
      int nb, pick;
      a = 4'($urandom);
      c = ($urandom % 4 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      d = 10'($urandom);
      pick = $urandom % 10;
      nb = (pick < 6) ? 16 : (pick == 6) ? 15 : (pick == 7) ? 17 : (pick == 8) ? 8 : 3;
      run_frame(a, c, d, nb, 0, cm);
      if (cm) begin
        chk("R5", "busy after random commit", busy, 1);
        chk("R4", "store before commit end", nv_o[tb_nv_idx(a)*10 +: 10], m_nv[tb_nv_idx(a)]);
        tick(COMMIT + 10);
        m_nv[tb_nv_idx(a)] = d;
      end else begin
        tick(4);
      end
      chk("R3", "busy idle between frames", busy, 0);
      check_regs("R4");
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule